// File: doc/BRIEF.md
# Parallel Panel Frame Write Sequencer

This block pushes one frame of pixel words to a display panel that keeps its own frame memory. It drives an 8080-style parallel write bus: an active-low chip select, an active-low write strobe and a data bus. Software arms a transfer with a trigger command. The block then takes the configured number of words from an upstream source, one per write cycle. When the last cycle ends it raises a frame-done interrupt that software clears by writing a 1, and it returns to idle.

Each write cycle is built from four phases whose lengths come from 4-bit fields of a configuration word: chip-select setup, write setup, write-active and write-hold. The timing and the word count are captured when a transfer starts. While a transfer is in progress, a new trigger is dropped, because a repeated trigger can reset the panel. Tearing-effect pulses from the panel pass through a synchronizer and are counted, so software can pace its triggers against the panel's refresh.

Top module: `i80_write_seq`

## Requirements
- R1: After reset, cs_n and wr_n are 1, busy and irq are 0, trig_stat is 0 and te_count is 0.
- R2: The configuration word carries the chip-select setup length in bits [19:16], the write setup length in [15:12], the write-active field in [11:8] and the write-hold field in [7:4]. Each word occupies CS + WS + (WA+1) + (WH+1) clocks. wr_n is low for exactly WA+1 clocks of each word and gives exactly one falling edge per word.
- R3: The word driven on db_out during the strobe of the k-th word of the run is the k-th value that px_data presented in a cycle with px_take high.
- R4: A trigger write (trig_wr with trig_wdata bit 1 = start command and bit 0 = parallel-bus trigger mode) sets the pending bit, trig_stat[1], on that clock edge. On the next edge the pending bit clears by itself and busy goes high. trig_stat[0] reads back the last written mode bit.
- R5: A trigger write while busy is 1 leaves the pending bit at 0 and starts no second transfer.
- R6: A trigger write is ignored when cfg_word bit 0 (interface enable) is 0, when the mode bit is 0, or when frame_words is 0.
- R7: busy stays high for exactly frame_words × (word length) clocks and falls when the hold phase of the last word ends. cs_n is low exactly while busy is high.
- R8: irq becomes 1 on the edge where busy falls and stays 1 until a clock with irq_clr high. If a clear and a frame end fall on the same edge, irq is 1.
- R9: Changes to cfg_word or frame_words after a transfer has started do not change that transfer.
- R10: te_count increments once per rising edge of te_in and wraps modulo 2^TE_W.
- R11: wr_n is never low while cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Phase lengths and interface enable |
| frame_words | input | CNT_W | Words in one frame |
| trig_wr | input | 1 | Trigger-control write strobe |
| trig_wdata | input | 2 | Bit 1 start command, bit 0 trigger mode |
| trig_stat | output | 2 | {pending, mode} |
| irq_clr | input | 1 | Write-1 clear of the frame-done interrupt |
| irq | output | 1 | Frame-done interrupt |
| busy | output | 1 | Transfer in progress |
| px_data | input | DW | Next pixel word |
| px_take | output | 1 | px_data is captured at this clock edge |
| te_in | input | 1 | Tearing-effect pulse from the panel |
| te_count | output | TE_W | Count of tearing-effect pulses |
| cs_n | output | 1 | Panel chip select, active low |
| wr_n | output | 1 | Panel write strobe, active low |
| db_out | output | DW | Panel data bus |

## Verification
The hardest case to reach from the ports is a frame end that coincides with something else: a software clear arriving on the exact edge where the last hold phase finishes, or a trigger arriving while the sequencer is mid-word. The bench computes the busy length arithmetically for each timing set. It then drives irq_clr on the negative edge before the last busy clock, and injects trigger writes and configuration changes at chosen busy-cycle counts. A sweep over many phase combinations, including all-zero setups and single-word frames, covers the phase-skipping paths.

// File: rtl/i80_pkg.sv
package i80_pkg;

   localparam int PHASE_W  = 4;
   localparam int CSS_LSB  = 16;
   localparam int WRS_LSB  = 12;
   localparam int WRA_LSB  = 8;
   localparam int WRH_LSB  = 4;
   localparam int EN_BIT   = 0;
   localparam int TRIG_MODE_BIT = 0;
   localparam int TRIG_CMD_BIT  = 1;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_CSS  = 3'd1,
      PH_WRS  = 3'd2,
      PH_WRA  = 3'd3,
      PH_WRH  = 3'd4
   } phase_e;

   typedef struct packed {
      logic [PHASE_W-1:0] css;
      logic [PHASE_W-1:0] wrs;
      logic [PHASE_W-1:0] wra;
      logic [PHASE_W-1:0] wrh;
   } timing_t;

   // first phase of a word: zero-length setup phases are skipped
   function automatic phase_e first_phase(input timing_t t);
      if (t.css != '0)      return PH_CSS;
      else if (t.wrs != '0) return PH_WRS;
      else                  return PH_WRA;
   endfunction

   // successor phase inside a word; PH_IDLE marks the end of the word
   function automatic phase_e next_phase(input phase_e p, input timing_t t);
      case (p)
         PH_CSS:  return (t.wrs != '0) ? PH_WRS : PH_WRA;
         PH_WRS:  return PH_WRA;
         PH_WRA:  return PH_WRH;
         PH_WRH:  return PH_IDLE;
         default: return first_phase(t);
      endcase
   endfunction

   // clocks spent in a phase, minus one
   function automatic logic [PHASE_W-1:0] phase_len_m1(input phase_e p, input timing_t t);
      case (p)
         PH_CSS:  return t.css - PHASE_W'(1);
         PH_WRS:  return t.wrs - PHASE_W'(1);
         PH_WRA:  return t.wra;
         PH_WRH:  return t.wrh;
         default: return '0;
      endcase
   endfunction

endpackage

// File: rtl/i80_cfg_decode.sv
module i80_cfg_decode
   import i80_pkg::*;
(
   input  logic [31:0] cfg_word,
   output timing_t     tim,
   output logic        if_en
);
   logic unused_cfg_bits;

   assign tim.css = cfg_word[CSS_LSB +: PHASE_W];
   assign tim.wrs = cfg_word[WRS_LSB +: PHASE_W];
   assign tim.wra = cfg_word[WRA_LSB +: PHASE_W];
   assign tim.wrh = cfg_word[WRH_LSB +: PHASE_W];
   assign if_en   = cfg_word[EN_BIT];

   assign unused_cfg_bits = ^{cfg_word[31:CSS_LSB+PHASE_W], cfg_word[WRH_LSB-1:EN_BIT+1]};
endmodule

// File: rtl/i80_frame_ctl.sv
module i80_frame_ctl
   import i80_pkg::*;
#(
   parameter int CNT_W = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_wr,
   input  logic [1:0]       trig_wdata,
   input  logic             if_en,
   input  logic [CNT_W-1:0] frame_words,
   input  logic             busy,
   input  logic             done,
   input  logic             irq_clr,
   output logic             start,
   output logic             mode_q,
   output logic             pend_q,
   output logic             irq_q
);
   logic accept;

   // a command is taken only while idle and fully enabled
   assign accept = trig_wr & trig_wdata[TRIG_CMD_BIT] & trig_wdata[TRIG_MODE_BIT]
                 & if_en & (frame_words != '0) & ~busy & ~pend_q;
   assign start  = pend_q & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         pend_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (trig_wr)
            mode_q <= trig_wdata[TRIG_MODE_BIT];
         if (start)
            pend_q <= 1'b0;
         else if (accept)
            pend_q <= 1'b1;
         if (done)
            irq_q <= 1'b1;
         else if (irq_clr)
            irq_q <= 1'b0;
      end
   end
endmodule

// File: rtl/i80_cycle_fsm.sv
module i80_cycle_fsm
   import i80_pkg::*;
#(
   parameter int CNT_W = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  timing_t          tim_in,
   input  logic [CNT_W-1:0] n_words,
   output phase_e           phase_o,
   output logic             take,
   output logic             done
);
   phase_e             phase_q;
   logic [PHASE_W-1:0] cnt_q;
   logic [CNT_W-1:0]   words_q;
   timing_t            tim_q;

   phase_e first_in, first_q, adv;
   logic   word_end, last_word;

   always_comb begin
      first_in = first_phase(tim_in);
      first_q  = first_phase(tim_q);
      adv      = next_phase(phase_q, tim_q);
   end

   assign word_end  = (phase_q == PH_WRH) && (cnt_q == '0);
   assign last_word = (words_q == CNT_W'(1));
   assign done      = word_end & last_word;
   assign take      = start | (word_end & ~last_word);
   assign phase_o   = phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         words_q <= '0;
         tim_q   <= '0;
      end else if (start) begin
         tim_q   <= tim_in;
         words_q <= n_words;
         phase_q <= first_in;
         cnt_q   <= phase_len_m1(first_in, tim_in);
      end else if (phase_q != PH_IDLE) begin
         if (cnt_q != '0) begin
            cnt_q <= cnt_q - PHASE_W'(1);
         end else if (word_end) begin
            if (last_word) begin
               phase_q <= PH_IDLE;
            end else begin
               words_q <= words_q - CNT_W'(1);
               phase_q <= first_q;
               cnt_q   <= phase_len_m1(first_q, tim_q);
            end
         end else begin
            phase_q <= adv;
            cnt_q   <= phase_len_m1(adv, tim_q);
         end
      end
   end
endmodule

// File: rtl/i80_te_count.sv
module i80_te_count #(
   parameter int SYNC_STAGES = 2,
   parameter int TE_W        = 8
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            te_in,
   output logic [TE_W-1:0] te_count
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   te_prev_q;
   logic                   te_rise;

   if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= te_in;
      end
   end else begin : g_sync_chain
      always_ff @(posedge clk) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], te_in};
      end
   end

   assign te_rise = sync_q[SYNC_STAGES-1] & ~te_prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         te_prev_q <= 1'b0;
         te_count  <= '0;
      end else begin
         te_prev_q <= sync_q[SYNC_STAGES-1];
         if (te_rise)
            te_count <= te_count + TE_W'(1);
      end
   end
endmodule

// File: rtl/i80_write_seq.sv
module i80_write_seq
   import i80_pkg::*;
#(
   parameter int DW          = 16,
   parameter int CNT_W       = 12,
   parameter int TE_W        = 8,
   parameter int SYNC_STAGES = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [31:0]      cfg_word,
   input  logic [CNT_W-1:0] frame_words,
   input  logic             trig_wr,
   input  logic [1:0]       trig_wdata,
   output logic [1:0]       trig_stat,
   input  logic             irq_clr,
   output logic             irq,
   output logic             busy,
   input  logic [DW-1:0]    px_data,
   output logic             px_take,
   input  logic             te_in,
   output logic [TE_W-1:0]  te_count,
   output logic             cs_n,
   output logic             wr_n,
   output logic [DW-1:0]    db_out
);
   if (DW < 1) begin : g_bad_dw
      $error("DW must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end
   if (TE_W < 1) begin : g_bad_te
      $error("TE_W must be at least 1");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (CSS_LSB + PHASE_W > 32) begin : g_bad_map
      $error("phase fields exceed the configuration word");
   end

   timing_t tim;
   logic    if_en;
   logic    start, done, mode_q, pend_q, irq_q;
   phase_e  phase;
   logic [DW-1:0] db_q;

   i80_cfg_decode u_dec (
      .cfg_word (cfg_word),
      .tim      (tim),
      .if_en    (if_en)
   );

   i80_frame_ctl #(.CNT_W(CNT_W)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_wr     (trig_wr),
      .trig_wdata  (trig_wdata),
      .if_en       (if_en),
      .frame_words (frame_words),
      .busy        (busy),
      .done        (done),
      .irq_clr     (irq_clr),
      .start       (start),
      .mode_q      (mode_q),
      .pend_q      (pend_q),
      .irq_q       (irq_q)
   );

   i80_cycle_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .tim_in  (tim),
      .n_words (frame_words),
      .phase_o (phase),
      .take    (px_take),
      .done    (done)
   );

   i80_te_count #(.SYNC_STAGES(SYNC_STAGES), .TE_W(TE_W)) u_te (
      .clk      (clk),
      .rst_n    (rst_n),
      .te_in    (te_in),
      .te_count (te_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       db_q <= '0;
      else if (px_take) db_q <= px_data;
   end

   assign busy      = (phase != PH_IDLE);
   assign cs_n      = ~busy;
   assign wr_n      = (phase != PH_WRA);
   assign db_out    = db_q;
   assign irq       = irq_q;
   assign trig_stat = {pend_q, mode_q};
endmodule

// File: rtl/i80_write_seq_chk.sv
module i80_write_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] cfg_word,
   input logic        cs_n,
   input logic        wr_n,
   input logic        busy,
   input logic [1:0]  trig_stat,
   input logic        irq,
   input logic        irq_clr
);
   logic [31:0] cfg_q;
   logic        busy_q;
   logic [3:0]  act_lat;
   logic [7:0]  run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         busy_q  <= 1'b0;
         act_lat <= '0;
         run_q   <= '0;
      end else begin
         cfg_q  <= cfg_word;
         busy_q <= busy;
         if (busy && !busy_q)
            act_lat <= cfg_q[11:8];
         run_q <= wr_n ? 8'd0 : 8'(run_q + 8'd1);
      end
   end

   AST_STROBE_IN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> !cs_n);                                               // R11
   AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |-> (run_q == 8'({4'd0, act_lat} + 8'd1)));          // R2
   AST_NO_PEND_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !trig_stat[1]);                                        // R5
   AST_PEND_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      trig_stat[1] |=> (!trig_stat[1] && busy));                      // R4
   AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> irq);                                           // R8
   AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr |=> (!irq || $fell(busy)));                             // R8
endmodule

bind i80_write_seq i80_write_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_word  (cfg_word),
   .cs_n      (cs_n),
   .wr_n      (wr_n),
   .busy      (busy),
   .trig_stat (trig_stat),
   .irq       (irq),
   .irq_clr   (irq_clr)
);

// File: tb/tb_i80_write_seq.sv
module tb_i80_write_seq;
   localparam int DW = 16;
   localparam int CNT_W = 12;
   localparam int TE_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [31:0]      cfg_word = '0;
   logic [CNT_W-1:0] frame_words = '0;
   logic             trig_wr = 1'b0;
   logic [1:0]       trig_wdata = '0;
   logic [1:0]       trig_stat;
   logic             irq_clr = 1'b0;
   logic             irq, busy, px_take, cs_n, wr_n;
   logic [DW-1:0]    px_data, db_out;
   logic             te_in = 1'b0;
   logic [TE_W-1:0]  te_count;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int idx = 0;
   int gfall = 0;

   always #10 clk = ~clk;

   i80_write_seq #(.DW(DW), .CNT_W(CNT_W), .TE_W(TE_W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .frame_words(frame_words),
      .trig_wr(trig_wr), .trig_wdata(trig_wdata), .trig_stat(trig_stat),
      .irq_clr(irq_clr), .irq(irq), .busy(busy), .px_data(px_data),
      .px_take(px_take), .te_in(te_in), .te_count(te_count),
      .cs_n(cs_n), .wr_n(wr_n), .db_out(db_out)
   );

   function automatic logic [DW-1:0] pat(input int k);
      return DW'(k * 37 + 5);
   endfunction

   assign px_data = pat(idx);
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && px_take) idx <= idx + 1;
   end

   function automatic logic [31:0] mk_cfg(input int css, input int wrs, input int wra,
                                          input int wrh, input bit en);
      return {12'd0, css[3:0], wrs[3:0], wra[3:0], wrh[3:0], 3'd0, en};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic clear_irq();
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
      chk(irq == 1'b0, "R8", "irq after write-1 clear", irq, 0);
   endtask

   // one frame; options: clear on the finishing edge, retrigger mid-frame, config change mid-frame
   task automatic run_frame(input int css, input int wrs, input int wra, input int wrh,
                            input int n, input bit clr_end, input bit retrig, input bit chg);
      int t, exp_busy, bc, csl, wl, wf, dbad;
      bit pw;
      t = css + wrs + wra + wrh + 2;
      exp_busy = n * t;
      cfg_word = mk_cfg(css, wrs, wra, wrh, 1'b1);
      frame_words = CNT_W'(n);
      @(negedge clk); trig_wr = 1'b1; trig_wdata = 2'b11;
      @(negedge clk); trig_wr = 1'b0;
      chk(trig_stat == 2'b11 && !busy, "R4", "pending set, not yet busy",
          {busy, trig_stat}, 3);
      bc = 0; csl = 0; wl = 0; wf = 0; dbad = 0; pw = 1'b1;
      for (int g = 0; g < 2000; g++) begin
         @(negedge clk);
         if (trig_wr) trig_wr = 1'b0;
         if (g == 0)
            chk(busy && !trig_stat[1], "R4", "pending self-clears as busy rises",
                {busy, trig_stat[1]}, 2);
         if (busy) bc++;
         if (!cs_n) csl++;
         if (!wr_n) begin
            wl++;
            if (pw) begin wf++; gfall++; end
            if (db_out !== pat(gfall - 1)) dbad++;
         end
         pw = wr_n;
         if (retrig && bc == 2) begin trig_wr = 1'b1; trig_wdata = 2'b11; end
         if (chg && bc == 3) begin
            cfg_word = mk_cfg(0, 0, 0, 0, 1'b1);
            frame_words = CNT_W'(1);
         end
         if (clr_end && bc == exp_busy) irq_clr = 1'b1;
         if (!busy && bc > 0) break;
      end
      irq_clr = 1'b0;
      chk(bc == exp_busy, chg ? "R9" : "R7", "busy clocks", bc, exp_busy);
      chk(csl == exp_busy, "R7", "cs_n low clocks", csl, exp_busy);
      chk(wl == n * (wra + 1), chg ? "R9" : "R2", "wr_n low clocks", wl, n * (wra + 1));
      chk(wf == n, "R2", "strobe falling edges", wf, n);
      chk(dbad == 0, "R3", "data mismatches during strobe", dbad, 0);
      chk(irq == 1'b1, "R8", clr_end ? "irq set wins over clear" : "irq at frame end", irq, 1);
      if (retrig) begin
         int extra;
         extra = 0;
         for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (busy || trig_stat[1]) extra++;
         end
         chk(extra == 0, "R5", "trigger during transfer ignored", extra, 0);
      end
      clear_irq();
   endtask

   task automatic try_ignored(input bit en, input bit mode, input int n, input string what);
      int bad;
      cfg_word = mk_cfg(1, 1, 1, 1, en);
      frame_words = CNT_W'(n);
      @(negedge clk); trig_wr = 1'b1; trig_wdata = {1'b1, mode};
      @(negedge clk); trig_wr = 1'b0;
      bad = 0;
      for (int k = 0; k < 6; k++) begin
         if (busy || !cs_n || trig_stat[1] || px_take) bad++;
         @(negedge clk);
      end
      chk(bad == 0, "R6", what, bad, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n && wr_n, "R1", "bus idle after reset", {cs_n, wr_n}, 3);
      chk(!busy && !irq, "R1", "busy and irq low after reset", {busy, irq}, 0);
      chk(trig_stat == 2'b00, "R1", "trigger status after reset", trig_stat, 0);
      chk(te_count == '0, "R1", "te_count after reset", te_count, 0);

      // R2 R3 R7: sweep of phase lengths and frame sizes
      begin
         int it;
         it = 0;
         for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
               for (int c = 0; c < 3; c++)
                  for (int d = 0; d < 3; d++) begin
                     run_frame(a, b, (c == 2) ? 6 : c, d, 1 + (it % 3), 1'b0, 1'b0, 1'b0);
                     it++;
                  end
      end
      run_frame(0, 0, 15, 0, 2, 1'b0, 1'b0, 1'b0);           // R2 widest strobe
      run_frame(15, 15, 15, 15, 1, 1'b0, 1'b0, 1'b0);        // R2 all fields at maximum
      run_frame(0, 1, 1, 0, 3, 1'b1, 1'b0, 1'b0);            // R8 clear on frame end edge
      run_frame(1, 0, 2, 1, 3, 1'b0, 1'b1, 1'b0);            // R5 retrigger while busy
      run_frame(1, 1, 3, 1, 4, 1'b0, 1'b0, 1'b1);            // R9 change config mid-frame

      try_ignored(1'b0, 1'b1, 3, "interface disabled");
      try_ignored(1'b1, 1'b0, 3, "mode bit clear");
      chk(trig_stat[0] == 1'b0, "R4", "mode readback", trig_stat[0], 0);
      try_ignored(1'b1, 1'b1, 0, "zero frame length");

      // R10: tearing-effect pulse counting with wrap
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); te_in = 1'b1; @(negedge clk); te_in = 1'b0; @(negedge clk);
      end
      repeat (5) @(negedge clk);
      chk(te_count == TE_W'(3), "R10", "te pulses counted", te_count, 3);
      for (int k = 0; k < 255; k++) begin
         @(negedge clk); te_in = 1'b1; @(negedge clk); te_in = 1'b0; @(negedge clk);
      end
      repeat (5) @(negedge clk);
      chk(te_count == TE_W'(2), "R10", "te count wraps", te_count, 2);

      summary();
   end

   initial begin
      forever begin
         @(posedge clk);
         if (cyc > 150000) begin
            chk(1'b0, "R7", "watchdog expired", cyc, 150000);
            summary();
         end
      end
   end
endmodule